// File: doc/BRIEF.md
# Legacy display cycle routing decoder

This block decides, for each processor transaction, whether a downstream graphics port claims it or whether it stays on the internal backbone. The decision covers memory and I/O cycles aimed at the legacy colour-display (VGA) and monochrome-adapter (MDA) address ranges. It uses a small control register that holds a monochrome-present flag and a DRAM-hole enable, together with the graphics port's own VGA-enable, memory-access-enable and I/O-access-enable bits and its I/O base/limit window. The same register enables a fixed one-megabyte DRAM hole just below the 16 MB line. The block flags memory accesses that land in that hole.

Transactions enter on a valid/ready stream and leave as decisions on a second valid/ready stream, through one output register. An input is taken on any cycle where `txn_valid` and `txn_ready` are both high. `txn_ready` is high whenever the output register is empty or its decision is being taken on the same cycle. A decision stays on the output, unchanged, until `dec_ready` is high. Each decision uses the register contents as they stood in the cycle the transaction was accepted. The register is written through a plain strobe and is always readable on `cfg_rd_data`.

Top module: `lrd_top`

## Requirements
- R1: After reset, `cfg_rd_data` reads 00h and `dec_valid` is low.
- R2: A write sets the hole-enable bit from data bit 7 and the monochrome-present bit from data bit 3. Every other bit reads as zero whatever is written.
- R3: While `hen_lock` is high, a write leaves bit 7 unchanged but still updates bit 3.
- R4: `dec_hole` is high exactly for a memory transaction with hole enable set and address in [F00000h, 1000000h). I/O transactions never raise it.
- R5: With VGA enable and memory-access enable set and monochrome-present clear, a memory address in A0000h–BFFFFh is claimed.
- R6: With monochrome-present set, memory addresses B0000h–B7FFFh are not claimed. The rest of A0000h–BFFFFh is still claimed.
- R7: An I/O access is decoded per active byte lane. Lane i of a 4-byte access addresses port {addr[15:2], i}, and port bits 15:10 are ignored. VGA ports 3B0h–3BBh and 3C0h–3DFh are claimed when VGA enable and I/O-access enable are set.
- R8: With monochrome-present set, an I/O access with any active lane on port 3B4h, 3B5h, 3B8h, 3B9h, 3BAh or 3BFh (or any alias) stays on the backbone as a whole, even if its other lanes are VGA ports.
- R9: With VGA enable set and monochrome-present clear, an access is claimed only if every active lane on ports 3BCh–3BFh has its full 16-bit port inside [`io_base`, `io_limit`].
- R10: With VGA enable clear, nothing is claimed. If monochrome-present is also set, `cfg_err` is high.
- R11: A memory claim needs `mem_access_en`, and an I/O claim needs `io_access_en`. An access whose active lanes hit no legacy port is not claimed.
- R12: `txn_ready` equals `!dec_valid || dec_ready`. While `dec_valid` is high and `dec_ready` is low, the decision outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_data | input | 8 | Register write data |
| hen_lock | input | 1 | Freezes the hole-enable bit |
| cfg_rd_data | output | 8 | Register contents |
| cfg_err | output | 1 | Illegal VGA-off / mono-present combination |
| vga_en | input | 1 | Graphics port VGA enable |
| mem_access_en | input | 1 | Graphics port memory access enable |
| io_access_en | input | 1 | Graphics port I/O access enable |
| io_base | input | 16 | Graphics port I/O window base |
| io_limit | input | 16 | Graphics port I/O window limit (inclusive) |
| txn_valid | input | 1 | Transaction valid |
| txn_ready | output | 1 | Transaction accepted when high with valid |
| txn_is_io | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| txn_addr | input | 32 | Transaction address |
| txn_be | input | 4 | Byte-lane enables |
| dec_valid | output | 1 | Decision valid |
| dec_ready | input | 1 | Decision taken when high with valid |
| dec_claim | output | 1 | 1 = graphics port claims the cycle |
| dec_hole | output | 1 | 1 = address falls in the enabled DRAM hole |

## Verification
A wrong monochrome-present or hole-enable bit appears on `cfg_rd_data` in the cycle after the write that set it. It also flips `dec_claim` or `dec_hole` on the next transaction that touches an affected range, one cycle after that transaction is accepted. A lane-decode or alias fault shows only for the specific port and byte-enable pattern that hits it. That is why the bench drives many lanes, aliases and window positions and compares every decision against a model on every clock. A fault in the output register under back-pressure shows the same cycle as a decision that changes or disappears while `dec_ready` is low.

// File: rtl/lrd_pkg.sv
package lrd_pkg;
  localparam int unsigned IO_PORT_W = 16;
  localparam int unsigned IO_DEC_W  = 10;

  localparam logic [IO_DEC_W-1:0] VGA_IO_A_LO = 10'h3B0;
  localparam logic [IO_DEC_W-1:0] VGA_IO_A_HI = 10'h3BB;
  localparam logic [IO_DEC_W-1:0] VGA_IO_B_LO = 10'h3C0;
  localparam logic [IO_DEC_W-1:0] VGA_IO_B_HI = 10'h3DF;
  localparam logic [IO_DEC_W-1:0] GATED_LO    = 10'h3BC;
  localparam logic [IO_DEC_W-1:0] GATED_HI    = 10'h3BF;

  localparam logic [31:0] VGA_MEM_LO = 32'h000A_0000;
  localparam logic [31:0] VGA_MEM_HI = 32'h000B_FFFF;
  localparam logic [31:0] MDA_MEM_LO = 32'h000B_0000;
  localparam logic [31:0] MDA_MEM_HI = 32'h000B_7FFF;

  localparam int unsigned HEN_BIT  = 7;
  localparam int unsigned MDAP_BIT = 3;

  typedef struct packed {
    logic is_mda;
    logic is_vga;
    logic is_gated;
    logic in_win;
  } lane_class_t;

  typedef struct packed {
    logic claim;
    logic hole;
  } decision_t;

  function automatic logic is_mda_port(input logic [IO_DEC_W-1:0] p);
    case (p)
      10'h3B4, 10'h3B5, 10'h3B8, 10'h3B9, 10'h3BA, 10'h3BF: is_mda_port = 1'b1;
      default: is_mda_port = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/lrd_ctl_reg.sv
module lrd_ctl_reg
  import lrd_pkg::*;
#(
  parameter int unsigned REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             lock,
  output logic             hen,
  output logic             mdap,
  output logic [REG_W-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hen  <= 1'b0;
      mdap <= 1'b0;
    end else if (wr_en) begin
      mdap <= wr_data[MDAP_BIT];
      if (!lock) hen <= wr_data[HEN_BIT];
    end
  end

  always_comb begin
    rd_data           = '0;
    rd_data[HEN_BIT]  = hen;
    rd_data[MDAP_BIT] = mdap;
  end

  // R3: locked hole enable does not move
  p_hen_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && lock) |=> (hen == $past(hen)));

  // R2: mono-present follows every write
  p_mdap_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mdap == $past(wr_data[MDAP_BIT])));
endmodule

// File: rtl/lrd_io_lane.sv
module lrd_io_lane
  import lrd_pkg::*;
(
  input  logic [IO_PORT_W-1:0] port,
  input  logic [IO_PORT_W-1:0] win_base,
  input  logic [IO_PORT_W-1:0] win_limit,
  output lane_class_t          cls
);
  logic [IO_DEC_W-1:0] p10;

  always_comb begin
    p10          = port[IO_DEC_W-1:0];
    cls.is_mda   = is_mda_port(p10);
    cls.is_vga   = ((p10 >= VGA_IO_A_LO) && (p10 <= VGA_IO_A_HI)) ||
                   ((p10 >= VGA_IO_B_LO) && (p10 <= VGA_IO_B_HI));
    cls.is_gated = (p10 >= GATED_LO) && (p10 <= GATED_HI);
    cls.in_win   = (port >= win_base) && (port <= win_limit);
  end
endmodule

// File: rtl/lrd_route.sv
module lrd_route
  import lrd_pkg::*;
#(
  parameter int unsigned ADDR_W       = 32,
  parameter int unsigned BE_W         = 4,
  parameter int unsigned HOLE_BASE_MB = 15
) (
  input  logic                 is_io,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [BE_W-1:0]      be,
  input  logic                 hen,
  input  logic                 mdap,
  input  logic                 vga_en,
  input  logic                 mae,
  input  logic                 ioae,
  input  logic [IO_PORT_W-1:0] io_base,
  input  logic [IO_PORT_W-1:0] io_limit,
  output decision_t            dec
);
  localparam int unsigned LANE_BITS = (BE_W > 1) ? $clog2(BE_W) : 1;
  localparam logic [ADDR_W-1:0] HOLE_LO = ADDR_W'(64'(HOLE_BASE_MB) << 20);
  localparam logic [ADDR_W-1:0] HOLE_HI = ADDR_W'(64'(HOLE_BASE_MB + 1) << 20);

  lane_class_t    cls [BE_W];
  logic [BE_W-1:0] hit_mda, hit_legacy, gate_fail;

  for (genvar i = 0; i < BE_W; i++) begin : g_lane
    logic [IO_PORT_W-1:0] lane_port;
    if (BE_W > 1) begin : g_multi
      assign lane_port = {addr[IO_PORT_W-1:LANE_BITS], LANE_BITS'(i)};
    end else begin : g_single
      assign lane_port = addr[IO_PORT_W-1:0];
    end
    lrd_io_lane u_lane (
      .port      (lane_port),
      .win_base  (io_base),
      .win_limit (io_limit),
      .cls       (cls[i])
    );
    assign hit_mda[i]    = be[i] && cls[i].is_mda;
    assign hit_legacy[i] = be[i] && (cls[i].is_mda || cls[i].is_vga || cls[i].is_gated);
    assign gate_fail[i]  = be[i] && cls[i].is_gated && !cls[i].in_win;
  end

  logic in_vga_mem, in_mda_mem, in_hole, io_claim, mem_claim;

  always_comb begin
    in_vga_mem = (addr >= ADDR_W'(VGA_MEM_LO)) && (addr <= ADDR_W'(VGA_MEM_HI));
    in_mda_mem = (addr >= ADDR_W'(MDA_MEM_LO)) && (addr <= ADDR_W'(MDA_MEM_HI));
    in_hole    = (addr >= HOLE_LO) && (addr < HOLE_HI);

    mem_claim  = vga_en && mae && in_vga_mem && !(mdap && in_mda_mem);
    io_claim   = vga_en && ioae && (|hit_legacy) && !(mdap && (|hit_mda)) &&
                 !(|gate_fail);

    dec.claim  = is_io ? io_claim : mem_claim;
    dec.hole   = !is_io && hen && in_hole;
  end
endmodule

// File: rtl/lrd_top.sv
module lrd_top
  import lrd_pkg::*;
#(
  parameter int unsigned ADDR_W       = 32,
  parameter int unsigned BE_W         = 4,
  parameter int unsigned REG_W        = 8,
  parameter int unsigned HOLE_BASE_MB = 15
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr_en,
  input  logic [REG_W-1:0]     cfg_wr_data,
  input  logic                 hen_lock,
  output logic [REG_W-1:0]     cfg_rd_data,
  output logic                 cfg_err,
  input  logic                 vga_en,
  input  logic                 mem_access_en,
  input  logic                 io_access_en,
  input  logic [IO_PORT_W-1:0] io_base,
  input  logic [IO_PORT_W-1:0] io_limit,
  input  logic                 txn_valid,
  output logic                 txn_ready,
  input  logic                 txn_is_io,
  input  logic [ADDR_W-1:0]    txn_addr,
  input  logic [BE_W-1:0]      txn_be,
  output logic                 dec_valid,
  input  logic                 dec_ready,
  output logic                 dec_claim,
  output logic                 dec_hole
);
  logic      hen, mdap;
  decision_t next_dec;

  lrd_ctl_reg #(.REG_W(REG_W)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr_en),
    .wr_data (cfg_wr_data),
    .lock    (hen_lock),
    .hen     (hen),
    .mdap    (mdap),
    .rd_data (cfg_rd_data)
  );

  lrd_route #(
    .ADDR_W       (ADDR_W),
    .BE_W         (BE_W),
    .HOLE_BASE_MB (HOLE_BASE_MB)
  ) u_route (
    .is_io    (txn_is_io),
    .addr     (txn_addr),
    .be       (txn_be),
    .hen      (hen),
    .mdap     (mdap),
    .vga_en   (vga_en),
    .mae      (mem_access_en),
    .ioae     (io_access_en),
    .io_base  (io_base),
    .io_limit (io_limit),
    .dec      (next_dec)
  );

  assign cfg_err   = mdap && !vga_en;
  assign txn_ready = !dec_valid || dec_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid <= 1'b0;
      dec_claim <= 1'b0;
      dec_hole  <= 1'b0;
    end else if (txn_ready) begin
      dec_valid <= txn_valid;
      dec_claim <= txn_valid && next_dec.claim;
      dec_hole  <= txn_valid && next_dec.hole;
    end
  end

  // R12: stalled decision holds
  p_stall_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_ready) |=> (dec_valid && $stable(dec_claim) && $stable(dec_hole)));

  // R11: I/O claim needs I/O access enable
  p_ioae_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && txn_ready && txn_is_io && !io_access_en) |=> !dec_claim);

  // R4: I/O never flags the hole
  p_io_no_hole_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && txn_ready && txn_is_io) |=> !dec_hole);

  // R10: illegal combination claims nothing
  p_illegal_noclaim_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && txn_ready && cfg_err) |=> !dec_claim);
endmodule

// File: tb/lrd_top_test.sv
module lrd_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [7:0]  cfg_wr_data = '0;
  logic        hen_lock = 1'b0;
  logic [7:0]  cfg_rd_data;
  logic        cfg_err;
  logic        vga_en = 1'b0, mem_access_en = 1'b0, io_access_en = 1'b0;
  logic [15:0] io_base = '0, io_limit = '0;
  logic        txn_valid = 1'b0;
  logic        txn_ready;
  logic        txn_is_io = 1'b0;
  logic [31:0] txn_addr = '0;
  logic [3:0]  txn_be = '0;
  logic        dec_valid;
  logic        dec_ready = 1'b1;
  logic        dec_claim, dec_hole;

  int n_cmp = 0, n_bad = 0;
  int cycles = 0;
  bit done = 0;
  bit rand_ready = 0;
  string cur_tag = "R5";

  bit m_hen = 0, m_mdap = 0;
  bit q_claim[$];
  bit q_hole[$];
  string q_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  lrd_top uut (.*);

  task automatic check(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit mda_port(input int p);
    int q = p % 1024;
    return q == 'h3B4 || q == 'h3B5 || q == 'h3B8 || q == 'h3B9 || q == 'h3BA || q == 'h3BF;
  endfunction

  function automatic bit model_claim();
    if (!vga_en) return 0;
    if (!txn_is_io) begin
      if (!mem_access_en) return 0;
      if (txn_addr < 32'hA0000 || txn_addr > 32'hBFFFF) return 0;
      if (m_mdap && txn_addr >= 32'hB0000 && txn_addr <= 32'hB7FFF) return 0;
      return 1;
    end else begin
      bit legacy = 0;
      if (!io_access_en) return 0;
      for (int i = 0; i < 4; i++) begin
        if (txn_be[i]) begin
          int port = (int'(txn_addr[15:0]) / 4) * 4 + i;
          int low  = port % 1024;
          bit vga  = (low >= 'h3B0 && low <= 'h3BB) || (low >= 'h3C0 && low <= 'h3DF);
          bit gate = (low >= 'h3BC && low <= 'h3BF);
          if (m_mdap && mda_port(port)) return 0;
          if (gate && !(port >= int'(io_base) && port <= int'(io_limit))) return 0;
          if (vga || gate || mda_port(port)) legacy = 1;
        end
      end
      return legacy;
    end
  endfunction

  // per-cycle reference compare, at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      check("R12", "txn_ready", txn_ready, !dec_valid || dec_ready);
      check("R12", "dec_valid", dec_valid, q_claim.size() > 0);
      if (dec_valid && q_claim.size() > 0) begin
        check(q_tag[0], "dec_claim", dec_claim, q_claim[0]);
        check(q_tag[0] == "R4" ? "R4" : "R4", "dec_hole", dec_hole, q_hole[0]);
      end
      check("R2", "cfg_rd_data", cfg_rd_data, {m_hen, 3'b000, m_mdap, 3'b000});
      check("R10", "cfg_err", cfg_err, m_mdap && !vga_en);
      if (dec_valid && dec_ready && q_claim.size() > 0) begin
        void'(q_claim.pop_front()); void'(q_hole.pop_front()); void'(q_tag.pop_front());
      end
      if (txn_valid && txn_ready) begin
        q_claim.push_back(model_claim());
        q_hole.push_back(!txn_is_io && m_hen && txn_addr >= 32'hF00000 && txn_addr < 32'h1000000);
        q_tag.push_back(cur_tag);
      end
      if (cfg_wr_en) begin
        m_mdap = cfg_wr_data[3];
        if (!hen_lock) m_hen = cfg_wr_data[7];
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk); #1;
      dec_ready = rand_ready ? ($urandom_range(0, 3) != 0) : 1'b1;
    end
  end

  task automatic wreg(input logic [7:0] d, input logic lk);
    @(posedge clk); #1;
    cfg_wr_en = 1; cfg_wr_data = d; hen_lock = lk;
    @(posedge clk); #1;
    cfg_wr_en = 0; hen_lock = 0;
  endtask

  task automatic send(input string tag, input logic io, input logic [31:0] a, input logic [3:0] be);
    @(posedge clk); #1;
    cur_tag = tag; txn_valid = 1; txn_is_io = io; txn_addr = a; txn_be = be;
    while (!txn_ready) begin @(posedge clk); #1; end
    @(posedge clk); #1;
    txn_valid = 0;
  endtask

  task automatic ports(input logic v, input logic m, input logic i);
    @(posedge clk); #1;
    vga_en = v; mem_access_en = m; io_access_en = i;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", "reset cfg_rd_data", cfg_rd_data, 0);
    check("R1", "reset dec_valid", dec_valid, 0);
    rst_n = 1;

    // R2 register fields, reserved bits
    wreg(8'hFF, 0);
    wreg(8'h00, 0);
    // R3 lock
    wreg(8'h88, 0);
    wreg(8'h00, 1);
    wreg(8'h08, 1);
    wreg(8'h80, 0);

    // R4 hole boundaries
    send("R4", 0, 32'h00EF_FFFF, 4'hF);
    send("R4", 0, 32'h00F0_0000, 4'hF);
    send("R4", 0, 32'h00FF_FFFF, 4'hF);
    send("R4", 0, 32'h0100_0000, 4'hF);
    send("R4", 1, 32'h00F0_0000, 4'hF);
    wreg(8'h00, 0);
    send("R4", 0, 32'h00F0_0000, 4'hF);

    // R5, R6 memory
    ports(1, 1, 1);
    send("R5", 0, 32'h000A_0000, 4'hF);
    send("R5", 0, 32'h000B_FFFF, 4'hF);
    send("R5", 0, 32'h0009_FFFF, 4'hF);
    send("R5", 0, 32'h000B_4000, 4'hF);
    wreg(8'h08, 0);
    send("R6", 0, 32'h000B_4000, 4'hF);
    send("R6", 0, 32'h000B_7FFF, 4'hF);
    send("R6", 0, 32'h000B_8000, 4'hF);
    send("R6", 0, 32'h000A_8000, 4'hF);

    // R7, R8 I/O with aliasing
    wreg(8'h00, 0);
    send("R7", 1, 32'h0000_03C0, 4'h1);
    send("R7", 1, 32'h0000_FBD8, 4'h8);
    send("R7", 1, 32'h0000_03E0, 4'h1);
    send("R7", 1, 32'h0000_07B4, 4'h3);
    wreg(8'h08, 0);
    send("R8", 1, 32'h0000_03B4, 4'h1);
    send("R8", 1, 32'h0000_0BB8, 4'h6);
    send("R8", 1, 32'h0000_03B4, 4'h4);
    send("R8", 1, 32'h0000_03B0, 4'hF);
    send("R8", 1, 32'h0000_03BC, 4'h8);

    // R9 window on 3BC-3BF
    wreg(8'h00, 0);
    io_base = 16'h03BC; io_limit = 16'h03BE;
    send("R9", 1, 32'h0000_03BC, 4'h7);
    send("R9", 1, 32'h0000_03BC, 4'hF);
    send("R9", 1, 32'h0000_07BC, 4'h1);
    io_base = 16'h0000; io_limit = 16'hFFFF;
    send("R9", 1, 32'h0000_07BC, 4'hF);

    // R10 VGA disabled, illegal combo
    ports(0, 1, 1);
    send("R10", 0, 32'h000A_0000, 4'hF);
    send("R10", 1, 32'h0000_03C0, 4'hF);
    wreg(8'h08, 0);
    send("R10", 0, 32'h000A_0000, 4'hF);

    // R11 gating
    wreg(8'h00, 0);
    ports(1, 0, 1);
    send("R11", 0, 32'h000A_0000, 4'hF);
    send("R11", 1, 32'h0000_03C0, 4'hF);
    ports(1, 1, 0);
    send("R11", 1, 32'h0000_03C0, 4'hF);
    send("R11", 0, 32'h000A_0000, 4'hF);
    ports(1, 1, 1);
    send("R11", 1, 32'h0000_03C0, 4'h0);
    send("R11", 1, 32'h0000_0080, 4'hF);

    // R12 back-pressure with mixed random traffic
    rand_ready = 1;
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] a;
      logic io = $urandom_range(0, 1);
      if (k % 97 == 0) wreg(8'($urandom), $urandom_range(0, 1));
      if (k % 53 == 0) begin
        ports($urandom_range(0, 3) != 0, $urandom_range(0, 3) != 0, $urandom_range(0, 3) != 0);
        io_base = 16'h0300 + 16'($urandom_range(0, 255));
        io_limit = io_base + 16'($urandom_range(0, 512));
      end
      if (io) a = {16'h0, 6'($urandom), 4'hE, 6'($urandom)};
      else case ($urandom_range(0, 2))
        0: a = 32'h000A_0000 + 32'($urandom_range(0, 32'h1FFFF));
        1: a = 32'h00EF_0000 + 32'($urandom_range(0, 32'h12FFFF));
        default: a = $urandom;
      endcase
      send("R12", io, a, 4'($urandom));
    end
    rand_ready = 0;
    repeat (5) @(posedge clk);
    done = 1;
  end

  initial begin
    while (!done && cycles < WATCHDOG) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R12 watchdog: actual=%0d expected<%0d", cycles, WATCHDOG);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule